// File: doc/BRIEF.md
# Break-before-make gate sequencer with undriven-input park

This block sits between a pulse-width command and the two gate drivers of a synchronous buck stage. It turns the one command into a high-side enable and a low-side enable. On every edge of the command, the enable that is currently on is released first. The opposite enable is raised only after a fixed gap, counted in clock cycles, during which both are off. This gap keeps the two switches from conducting at the same time.

The command arrives as two digital comparator flags: one flag says the input is above the upper threshold, the other says it is below the lower threshold. Each flag passes through a two-flop synchronizer. The synchronized pair is then classified as a HIGH, LOW or mid-level (undriven) command. A mid-level input keeps the last valid command. If the input stays mid-level for longer than a programmable number of cycles, both enables are parked off and a status flag is raised. The block leaves park through a normal sequence once a valid level returns.

The dead time and the float timeout are the parameters `DEAD_CYCLES` (at least 1) and `FLOAT_CYCLES` (at least 2).

Top module: `gdrv_deadtime_ctrl`

## Requirements
- R1: While `rst_n` is low, and after its release, `gate_hi`, `gate_lo` and `float_detected` are 0. Both enables stay off until the first valid level. That level's enable then turns on `DEAD_CYCLES` edges after the sequencer first acts on the level.
- R2: The command encoding is as follows. `in_above_vih`=1 with `in_below_vil`=0 is HIGH. `in_below_vil`=1 with `in_above_vih`=0 is LOW. Both flags 0, or both flags 1, is mid-level. Each flag goes through two flops, so a change sampled on rising edge k is acted on at edge k+2. The outputs do not change before that edge.
- R3: On the edge that acts on a HIGH command, `gate_lo` clears. `gate_hi` sets exactly `DEAD_CYCLES` edges later, provided no LOW command was acted on in between.
- R4: On the edge that acts on a LOW command, `gate_hi` clears. `gate_lo` sets exactly `DEAD_CYCLES` edges later, provided no HIGH command was acted on in between.
- R5: `gate_hi` and `gate_lo` are never 1 in the same cycle.
- R6: If the command reverses inside the dead-time window, the pending enable never turns on. The dead time of the opposite enable restarts from the edge that acts on the reversal.
- R7: A mid-level input that lasts fewer than `FLOAT_CYCLES` acted-on edges changes none of the outputs, and the previous command stays in force.
- R8: A mid-level input held for `FLOAT_CYCLES` acted-on edges clears both enables and sets `float_detected` on that edge. Both enables stay off while `float_detected` is 1.
- R9: Any valid sample clears the float timer. Mid-level stretches that are each shorter than `FLOAT_CYCLES` and separated by a valid sample never park the block.
- R10: `float_detected` clears on the edge that acts on a valid level. The matching enable then sets after a full `DEAD_CYCLES` gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_above_vih | input | 1 | Comparator flag: input above upper threshold (asynchronous) |
| in_below_vil | input | 1 | Comparator flag: input below lower threshold (asynchronous) |
| gate_hi | output | 1 | High-side switch enable |
| gate_lo | output | 1 | Low-side switch enable |
| float_detected | output | 1 | Both switches parked off after an undriven input |

## Verification
Count the rising edges from the first one that samples a changed input as edge 1. That edge reaches the sequencer at edge 3. The released enable drops on edge 3, the opposite enable rises on edge 3+`DEAD_CYCLES`, and park takes effect on edge 2+`FLOAT_CYCLES`. The bench drives inputs on falling edges. After every rising edge it compares all three outputs, at the following falling edge, with values derived from these edge counts. It sweeps command pulse widths across the dead window and mid-level lengths across the timeout, so each boundary is hit one cycle early, exactly, and one cycle late.

// File: rtl/gdrv_pkg.sv
package gdrv_pkg;

    typedef enum logic [1:0] {
        LV_MID  = 2'b00,
        LV_LOW  = 2'b01,
        LV_HIGH = 2'b10
    } level_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PARK,
        ST_WAIT_HI,
        ST_HI_ON,
        ST_WAIT_LO,
        ST_LO_ON
    } drv_state_e;

endpackage

// File: rtl/gdrv_sync2.sv
module gdrv_sync2 #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.meta   = async_i;
        s_d.stable = s_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sync_o = s_q.stable;
endmodule

// File: rtl/gdrv_level_class.sv
module gdrv_level_class
    import gdrv_pkg::*;
(
    input  logic   above_s,
    input  logic   below_s,
    output level_e level
);
    // Opposite flags together are contradictory and are treated as undriven.
    always_comb begin
        unique case ({above_s, below_s})
            2'b10:   level = LV_HIGH;
            2'b01:   level = LV_LOW;
            default: level = LV_MID;
        endcase
    end
endmodule

// File: rtl/gdrv_float_timer.sv
module gdrv_float_timer #(
    parameter int FLOAT_CYCLES = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic is_mid,
    output logic fire
);
    localparam int CW = $clog2(FLOAT_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(FLOAT_CYCLES - 1);
    localparam logic [CW-1:0] SAT  = CW'(FLOAT_CYCLES);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (!is_mid)
            t_d.cnt = '0;
        else if (t_q.cnt != SAT)
            t_d.cnt = t_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    // One-cycle pulse on the edge that completes the timeout window.
    assign fire = is_mid && (t_q.cnt == LAST);
endmodule

// File: rtl/gdrv_deadtime_seq.sv
module gdrv_deadtime_seq
    import gdrv_pkg::*;
#(
    parameter int DEAD_CYCLES = 4
) (
    input  logic   clk,
    input  logic   rst_n,
    input  level_e level,
    input  logic   float_fire,
    output logic   gate_hi,
    output logic   gate_lo,
    output logic   parked
);
    localparam int DW = $clog2(DEAD_CYCLES + 1);
    localparam logic [DW-1:0] DLAST = DW'(DEAD_CYCLES - 1);

    typedef struct packed {
        drv_state_e    state;
        logic [DW-1:0] cnt;
    } seq_t;

    seq_t q_d, q_q;

    always_comb begin
        q_d = q_q;
        unique case (q_q.state)
            ST_IDLE, ST_PARK: begin
                if (level == LV_HIGH) begin
                    q_d.state = ST_WAIT_HI;
                    q_d.cnt   = '0;
                end else if (level == LV_LOW) begin
                    q_d.state = ST_WAIT_LO;
                    q_d.cnt   = '0;
                end
            end
            ST_WAIT_HI: begin
                if (level == LV_LOW) begin
                    q_d.state = ST_WAIT_LO;
                    q_d.cnt   = '0;
                end else if (q_q.cnt == DLAST) begin
                    q_d.state = ST_HI_ON;
                end else begin
                    q_d.cnt = q_q.cnt + 1'b1;
                end
            end
            ST_HI_ON: begin
                if (level == LV_LOW) begin
                    q_d.state = ST_WAIT_LO;
                    q_d.cnt   = '0;
                end
            end
            ST_WAIT_LO: begin
                if (level == LV_HIGH) begin
                    q_d.state = ST_WAIT_HI;
                    q_d.cnt   = '0;
                end else if (q_q.cnt == DLAST) begin
                    q_d.state = ST_LO_ON;
                end else begin
                    q_d.cnt = q_q.cnt + 1'b1;
                end
            end
            ST_LO_ON: begin
                if (level == LV_HIGH) begin
                    q_d.state = ST_WAIT_HI;
                    q_d.cnt   = '0;
                end
            end
            default: begin
                q_d.state = ST_IDLE;
                q_d.cnt   = '0;
            end
        endcase
        // The timeout only fires on a mid-level sample, so it never competes
        // with a valid-level transition above.
        if (float_fire) begin
            q_d.state = ST_PARK;
            q_d.cnt   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q.state <= ST_IDLE;
            q_q.cnt   <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    assign gate_hi = (q_q.state == ST_HI_ON);
    assign gate_lo = (q_q.state == ST_LO_ON);
    assign parked  = (q_q.state == ST_PARK);
endmodule

// File: rtl/gdrv_deadtime_ctrl.sv
module gdrv_deadtime_ctrl
    import gdrv_pkg::*;
#(
    parameter int DEAD_CYCLES  = 4,
    parameter int FLOAT_CYCLES = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_above_vih,
    input  logic in_below_vil,
    output logic gate_hi,
    output logic gate_lo,
    output logic float_detected
);
    logic [1:0] flags_s;
    level_e     level;
    logic       lvl_hi, lvl_lo, lvl_mid;
    logic       float_fire;

    gdrv_sync2 #(.WIDTH(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({in_above_vih, in_below_vil}),
        .sync_o  (flags_s)
    );

    gdrv_level_class u_class (
        .above_s (flags_s[1]),
        .below_s (flags_s[0]),
        .level   (level)
    );

    assign lvl_hi  = (level == LV_HIGH);
    assign lvl_lo  = (level == LV_LOW);
    assign lvl_mid = (level == LV_MID);

    gdrv_float_timer #(.FLOAT_CYCLES(FLOAT_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .is_mid (lvl_mid),
        .fire   (float_fire)
    );

    gdrv_deadtime_seq #(.DEAD_CYCLES(DEAD_CYCLES)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .level      (level),
        .float_fire (float_fire),
        .gate_hi    (gate_hi),
        .gate_lo    (gate_lo),
        .parked     (float_detected)
    );
endmodule

// File: rtl/gdrv_deadtime_chk.sv
module gdrv_deadtime_chk #(
    parameter int DEAD_CYCLES = 4
) (
    input logic clk,
    input logic rst_n,
    input logic gate_hi,
    input logic gate_lo,
    input logic float_detected,
    input logic lvl_is_hi,
    input logic lvl_is_lo
);
    localparam int OW = $clog2(DEAD_CYCLES + 2);
    localparam logic [OW-1:0] OSAT = OW'(DEAD_CYCLES);

    // Consecutive cycles with both enables off, saturating at the dead time.
    logic [OW-1:0] off_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            off_run_q <= '0;
        else if (gate_hi || gate_lo)
            off_run_q <= '0;
        else if (off_run_q != OSAT)
            off_run_q <= off_run_q + 1'b1;
    end

    p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi && gate_lo));

    p_hi_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_hi) |-> (off_run_q >= OSAT));

    p_lo_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_lo) |-> (off_run_q >= OSAT));

    p_hi_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_hi && lvl_is_lo) |=> !gate_hi);

    p_lo_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_lo && lvl_is_hi) |=> !gate_lo);

    p_float_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        float_detected |-> (!gate_hi && !gate_lo));

    p_float_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (float_detected && (lvl_is_hi || lvl_is_lo)) |=> !float_detected);
endmodule

bind gdrv_deadtime_ctrl gdrv_deadtime_chk #(.DEAD_CYCLES(DEAD_CYCLES)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .gate_hi        (gate_hi),
    .gate_lo        (gate_lo),
    .float_detected (float_detected),
    .lvl_is_hi      (lvl_hi),
    .lvl_is_lo      (lvl_lo)
);

// File: tb/gdrv_deadtime_ctrl_tb_top.sv
module gdrv_deadtime_ctrl_tb_top;
    localparam int DEAD = 3;
    localparam int FLT  = 6;

    // Input codes: 0 both flags low, 1 LOW, 2 HIGH, 3 both flags high.
    localparam int C_MID  = 0;
    localparam int C_LOW  = 1;
    localparam int C_HIGH = 2;
    localparam int C_BOTH = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic above = 1'b0;
    logic below = 1'b0;
    logic gh, gl, fd;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    gdrv_deadtime_ctrl #(.DEAD_CYCLES(DEAD), .FLOAT_CYCLES(FLT)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_above_vih   (above),
        .in_below_vil   (below),
        .gate_hi        (gh),
        .gate_lo        (gl),
        .float_detected (fd)
    );

    task automatic drive(input int code);
        above = (code == C_HIGH) || (code == C_BOTH);
        below = (code == C_LOW)  || (code == C_BOTH);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic eh, input logic el, input logic ef);
        n_chk++;
        if (gh !== eh || gl !== el || fd !== ef) begin
            n_fail++;
            $display("FAIL %s t=%0t: got hi=%b lo=%b float=%b, expected hi=%b lo=%b float=%b",
                     req, $time, gh, gl, fd, eh, el, ef);
        end
        n_chk++;
        if (gh === 1'b1 && gl === 1'b1) begin
            n_fail++;
            $display("FAIL R5 t=%0t: got hi=1 lo=1, expected at most one", $time);
        end
    endtask

    // Hold a valid level long enough for its enable to be on.
    task automatic settle(input int code);
        drive(code);
        repeat (DEAD + 6) tick();
        chk("R3/R4 settle", code == C_HIGH, code == C_LOW, 1'b0);
    endtask

    // Command pulse of w sampled cycles, then back to the opposite level.
    task automatic run_pulse(input int pol, input int w);
        int  base;
        bit  p_on, b_on;
        string tag;
        base = (pol == C_HIGH) ? C_LOW : C_HIGH;
        drive(pol);
        for (int n = 1; n <= w + DEAD + 5; n++) begin
            tick();
            p_on = (w > DEAD) && (n >= 3 + DEAD) && (n < 3 + w);
            b_on = (n < 3) || (n >= 3 + w + DEAD);
            if (n < 3)            tag = "R2";
            else if (w <= DEAD)   tag = "R6";
            else if (pol == C_HIGH) tag = "R3";
            else                  tag = "R4";
            if (pol == C_HIGH) chk(tag, p_on, b_on, 1'b0);
            else               chk(tag, b_on, p_on, 1'b0);
            if (n == w) drive(base);
        end
    endtask

    // Mid-level input of m sampled cycles, then back to base level.
    task automatic run_mid(input int base, input int m, input bit both);
        bit fired, b_on, f_on;
        string tag;
        fired = (m >= FLT);
        drive(both ? C_BOTH : C_MID);
        for (int n = 1; n <= m + DEAD + 5; n++) begin
            tick();
            f_on = fired && (n >= 2 + FLT) && (n < 3 + m);
            b_on = fired ? ((n < 2 + FLT) || (n >= 3 + m + DEAD)) : 1'b1;
            if (!fired)          tag = "R7";
            else if (n < 3 + m)  tag = "R8";
            else                 tag = "R10";
            chk(tag, (base == C_HIGH) && b_on, (base == C_LOW) && b_on, f_on);
            if (n == m) drive(base);
        end
    endtask

    initial begin
        drive(C_MID);
        repeat (3) tick();
        chk("R1 in reset", 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        repeat (2) tick();
        chk("R1 after release", 1'b0, 1'b0, 1'b0);

        // First valid level after reset.
        drive(C_LOW);
        for (int n = 1; n <= DEAD + 5; n++) begin
            tick();
            chk("R1 first level", 1'b0, n >= 3 + DEAD, 1'b0);
        end

        // Pulse width sweeps in both polarities.
        settle(C_LOW);
        for (int w = 1; w <= DEAD + 3; w++) run_pulse(C_HIGH, w);
        settle(C_HIGH);
        for (int w = 1; w <= DEAD + 3; w++) run_pulse(C_LOW, w);

        // Mid-level length sweeps from each level, both mid encodings.
        for (int b = 0; b < 2; b++) begin
            int base;
            base = (b == 0) ? C_HIGH : C_LOW;
            settle(base);
            for (int m = 1; m <= FLT + 2; m++) run_mid(base, m, m[0]);
        end

        // Interrupted mid stretches each one short of the timeout.
        settle(C_HIGH);
        drive(C_MID);
        for (int n = 1; n <= 2 * FLT + 4; n++) begin
            tick();
            chk("R9", 1'b1, 1'b0, 1'b0);
            if (n == FLT - 1)     drive(C_HIGH);
            if (n == FLT)         drive(C_BOTH);
            if (n == 2 * FLT - 1) drive(C_HIGH);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got no completion, expected end of sequence");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule